// File: doc/BRIEF.md
# Front-End Event Store with Roll Mode

This block holds event records for a multichannel front-end readout chip. Each record is a channel hit pattern plus a bunch-crossing identifier. The records sit in a small flop memory of `DEPTH` entries. A control bit, `roll_en`, picks the storage policy. With the bit low, the memory takes events until it holds `DEPTH` of them and then ignores the rest, so it keeps the earliest ones. With the bit high, the memory is a ring: it keeps accepting events, overwrites the oldest entry each time, and so always holds the most recent `DEPTH` events.

An acquisition sequencer uses the block in three steps. It pulses `acq_start` to clear the store. It then presents events during acquisition. It watches `mem_full` to learn when the memory is saturated. For readout, it pulses `rd_start`. The block then streams out every stored record, oldest first, one per cycle, and ends with a one-cycle `rd_done`. Readout does not destroy the contents, so it can be repeated.

Top module: `evt_store`

## Requirements
- R1: While `rst_n` is low at a rising edge, the store is emptied. After that edge, `mem_full`, `rd_valid` and `rd_done` are 0.
- R2: An event presented with `evt_valid` is stored on that edge if it is accepted. `mem_full` reads 1 from the edge that stores the `DEPTH`-th event of the acquisition.
- R3: With `roll_en` = 0 and `mem_full` = 1, further events are ignored. A later readout returns the first `DEPTH` events of the acquisition, in arrival order.
- R4: With `roll_en` = 1, events are still accepted when `mem_full` = 1, and each one overwrites the oldest entry. A later readout returns the last `DEPTH` events, oldest first.
- R5: When fewer than `DEPTH` events were stored, a readout returns exactly those events in arrival order, in either mode.
- R6: A `rd_start` pulse while idle makes the block present records with `rd_valid` = 1 on consecutive cycles, starting one cycle after the edge that samples `rd_start`. It presents exactly min(events, `DEPTH`) records. On the cycle after the last record, `rd_done` = 1 for one cycle. If the store is empty, `rd_done` comes on the cycle after the start edge.
- R7: `acq_start` empties the store and drops `mem_full` on the edge that samples it. An event presented on the same edge is discarded. A readout in progress stops with no further `rd_valid` and no `rd_done`.
- R8: Events presented during a readout are ignored. An event presented on the same edge as an accepted `rd_start` is also ignored. A `rd_start` during a readout is ignored. A readout leaves the contents and `mem_full` unchanged, so a repeated readout returns the same records.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| roll_en | input | 1 | 0: keep first events and stop when full; 1: ring that keeps the latest events |
| acq_start | input | 1 | Pulse that empties the store for a new acquisition |
| evt_valid | input | 1 | Event present this cycle |
| evt_hits | input | HIT_W | Channel hit pattern of the event |
| evt_bcid | input | BCID_W | Bunch-crossing identifier of the event |
| rd_start | input | 1 | Pulse that starts a readout |
| rd_valid | output | 1 | A record is on `rd_hits`/`rd_bcid` |
| rd_hits | output | HIT_W | Hit pattern of the presented record |
| rd_bcid | output | BCID_W | Crossing identifier of the presented record |
| rd_done | output | 1 | One-cycle pulse after the last record |
| mem_full | output | 1 | Memory saturated: `DEPTH` events stored |

## Verification
Inputs are driven on the falling edge and outputs are sampled on the following falling edge, half a cycle after the rising edge that acts.

- `mem_full` is checked after every single write. It is due right after the edge that stores the `DEPTH`-th event.
- Readout records are due on the falling edges that follow the second, third and later rising edges after `rd_start` is raised. `rd_done` is due one falling edge after the last record. The bench also confirms that `rd_valid` is still low half a cycle after the start edge.

The bench sweeps the event count from zero to well past a non-power-of-two depth in both modes. It computes each expected record from its arrival index.

// File: rtl/evt_store_pkg.sv
// Shared definitions for the event store: reader state encoding and the
// wrap-around index step used by both pointer owners.
package evt_store_pkg;

    typedef enum logic [0:0] {
        RS_IDLE   = 1'b0,
        RS_STREAM = 1'b1
    } rd_state_e;

    // Advance a ring index, returning to zero after depth-1 (any depth).
    function automatic int unsigned wrap_inc(int unsigned idx, int unsigned depth);
        return (idx + 1 >= depth) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/evt_store_wrptr.sv
// Write-side controller: owns the write pointer, the saturating event count
// and the full flag. Decides whether a requested write is accepted under the
// selected mode. Assumes wr_req is already blocked by the top during readout.
module evt_store_wrptr #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_req,
    input  logic          roll_en,
    output logic          wr_en,
    output logic [AW-1:0] wptr,
    output logic [CW-1:0] count,
    output logic          full
);
    import evt_store_pkg::*;

    logic [AW-1:0] wptr_q;
    logic [CW-1:0] count_q;

    // Accept a write unless clearing, or full in keep-first mode.
    always_comb begin
        wr_en = wr_req && !clr && (roll_en || !full);
    end

    // Full once the count reaches the depth.
    always_comb begin
        full = (count_q == CW'(DEPTH));
    end

    // Pointer and count update; count saturates at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr_q  <= '0;
            count_q <= '0;
        end else if (wr_en) begin
            wptr_q <= AW'(wrap_inc(32'(wptr_q), DEPTH));
            if (count_q != CW'(DEPTH)) begin
                count_q <= count_q + CW'(1);
            end
        end
    end

    assign wptr  = wptr_q;
    assign count = count_q;

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    a_r2_full_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && count_q == CW'(DEPTH - 1)) |=> full);

    a_r3_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!roll_en && full && wr_req && !clr) |=> ($stable(wptr_q) && $stable(count_q)));

    a_r4_roll_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_en && full && wr_req && !clr) |=> (full && wptr_q != $past(wptr_q)));

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0 && !full));

endmodule

// File: rtl/evt_store_mem.sv
// Record storage: DEPTH flop words with one synchronous write port and one
// asynchronous read port. No reset on contents; control logic tracks validity.
module evt_store_mem #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int W     = 20
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] cells [DEPTH];

    // Write the addressed word.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && wr_addr == AW'(i)) begin
                cells[i] <= wr_data;
            end
        end
    end

    // Select the addressed word for the reader.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_data = cells[i];
            end
        end
    end

endmodule

// File: rtl/evt_store_rdseq.sv
// Readout sequencer: on a start pulse it picks the oldest valid entry
// (the write pointer once a ring has wrapped, else entry 0). It streams the
// snapshot count of records one per cycle and then pulses done. Assumes the
// top blocks writes while busy, so the snapshot stays consistent.
module evt_store_rdseq #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int CW    = 4,
    parameter int W     = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          rd_start,
    input  logic          roll_en,
    input  logic          full,
    input  logic [AW-1:0] wptr,
    input  logic [CW-1:0] count,
    input  logic [W-1:0]  mem_data,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic          out_done
);
    import evt_store_pkg::*;

    rd_state_e     state_q;
    logic [AW-1:0] rptr_q;
    logic [CW-1:0] left_q;

    // Sequence the readout and register each presented record.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state_q   <= RS_IDLE;
            rptr_q    <= '0;
            left_q    <= '0;
            out_valid <= 1'b0;
            out_done  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_done  <= 1'b0;
            case (state_q)
                RS_IDLE: begin
                    if (rd_start) begin
                        rptr_q  <= (roll_en && full) ? wptr : '0;
                        left_q  <= count;
                        state_q <= RS_STREAM;
                    end
                end
                RS_STREAM: begin
                    if (left_q != '0) begin
                        out_valid <= 1'b1;
                        out_data  <= mem_data;
                        rptr_q    <= AW'(wrap_inc(32'(rptr_q), DEPTH));
                        left_q    <= left_q - CW'(1);
                    end else begin
                        out_done <= 1'b1;
                        state_q  <= RS_IDLE;
                    end
                end
                default: state_q <= RS_IDLE;
            endcase
        end
    end

    assign rd_addr = rptr_q;
    assign busy    = (state_q != RS_IDLE);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);

    a_r6_done_ends_stream: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_valid);

    a_r7_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!out_valid && !out_done));

endmodule

// File: rtl/evt_store.sv
// Event store top: packs incoming events into records, blocks writes while
// a readout is active or starting, and wires the write controller, storage
// and readout sequencer together. Assumes roll_en is held steady between
// acquisition start and readout.
module evt_store #(
    parameter int DEPTH  = 8,
    parameter int HIT_W  = 8,
    parameter int BCID_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              roll_en,
    input  logic              acq_start,
    input  logic              evt_valid,
    input  logic [HIT_W-1:0]  evt_hits,
    input  logic [BCID_W-1:0] evt_bcid,
    input  logic              rd_start,
    output logic              rd_valid,
    output logic [HIT_W-1:0]  rd_hits,
    output logic [BCID_W-1:0] rd_bcid,
    output logic              rd_done,
    output logic              mem_full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int W  = HIT_W + BCID_W;

    logic          busy;
    logic          wr_req;
    logic          wr_en;
    logic [AW-1:0] wptr;
    logic [CW-1:0] count;
    logic          full;
    logic [AW-1:0] rd_addr;
    logic [W-1:0]  mem_rdata;
    logic [W-1:0]  out_data;

    // Writes wait while a readout runs or is being started.
    always_comb begin
        wr_req = evt_valid && !busy && !rd_start;
    end

    evt_store_wrptr #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wrptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acq_start),
        .wr_req  (wr_req),
        .roll_en (roll_en),
        .wr_en   (wr_en),
        .wptr    (wptr),
        .count   (count),
        .full    (full)
    );

    evt_store_mem #(.DEPTH(DEPTH), .AW(AW), .W(W)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wptr),
        .wr_data ({evt_hits, evt_bcid}),
        .rd_addr (rd_addr),
        .rd_data (mem_rdata)
    );

    evt_store_rdseq #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .W(W)) u_rdseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (acq_start),
        .rd_start  (rd_start),
        .roll_en   (roll_en),
        .full      (full),
        .wptr      (wptr),
        .count     (count),
        .mem_data  (mem_rdata),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .out_valid (rd_valid),
        .out_data  (out_data),
        .out_done  (rd_done)
    );

    assign rd_hits  = out_data[W-1 -: HIT_W];
    assign rd_bcid  = out_data[BCID_W-1:0];
    assign mem_full = full;

    a_r8_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_en);

    a_r8_start_drops_event: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !busy) |-> !wr_en);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !rd_done && !mem_full));

endmodule

// File: tb/evt_store_test.sv
module evt_store_test;
    localparam int D      = 5;
    localparam int HIT_W  = 8;
    localparam int BCID_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              roll_en = 1'b0;
    logic              acq_start = 1'b0;
    logic              evt_valid = 1'b0;
    logic [HIT_W-1:0]  evt_hits = '0;
    logic [BCID_W-1:0] evt_bcid = '0;
    logic              rd_start = 1'b0;
    logic              rd_valid;
    logic [HIT_W-1:0]  rd_hits;
    logic [BCID_W-1:0] rd_bcid;
    logic              rd_done;
    logic              mem_full;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    evt_store #(.DEPTH(D), .HIT_W(HIT_W), .BCID_W(BCID_W)) uut (
        .clk(clk), .rst_n(rst_n), .roll_en(roll_en), .acq_start(acq_start),
        .evt_valid(evt_valid), .evt_hits(evt_hits), .evt_bcid(evt_bcid),
        .rd_start(rd_start), .rd_valid(rd_valid), .rd_hits(rd_hits),
        .rd_bcid(rd_bcid), .rd_done(rd_done), .mem_full(mem_full)
    );

    function automatic logic [HIT_W-1:0] f_hits(int idx, int tag);
        return HIT_W'(idx * 29 + tag * 71 + 3);
    endfunction

    function automatic logic [BCID_W-1:0] f_bcid(int idx, int tag);
        return BCID_W'(idx * 7 + tag * 300 + 1);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // New acquisition then n events; full checked after every write (R2).
    task automatic do_acq(input bit roll, input int n, input int tag);
        @(negedge clk);
        roll_en   = roll;
        acq_start = 1'b1;
        @(negedge clk);
        acq_start = 1'b0;
        check(mem_full == 1'b0, "R7 full cleared", mem_full, 0);
        for (int i = 0; i < n; i++) begin
            evt_valid = 1'b1;
            evt_hits  = f_hits(i, tag);
            evt_bcid  = f_bcid(i, tag);
            @(negedge clk);
            check(mem_full == (i + 1 >= D), "R2 full after write", mem_full, (i + 1 >= D));
        end
        evt_valid = 1'b0;
    endtask

    // Readout of an acquisition of n events; noise drives events and starts (R8).
    task automatic do_read(input bit roll, input int n, input int tag, input bit noise);
        int kept;
        int first;
        kept  = (n < D) ? n : D;
        first = roll ? n - kept : 0;
        rd_start  = 1'b1;
        evt_valid = noise;
        evt_hits  = 8'hEE;
        evt_bcid  = 12'hEEE;
        @(negedge clk);
        rd_start = noise;
        check(rd_valid == 1'b0 && rd_done == 1'b0, "R6 nothing on start edge", rd_valid, 0);
        for (int j = 0; j < kept; j++) begin
            @(negedge clk);
            check(rd_valid == 1'b1, "R6 record valid", rd_valid, 1);
            check(rd_hits == f_hits(first + j, tag),
                  roll ? "R4 roll hits" : (n < D ? "R5 partial hits" : "R3 first hits"),
                  rd_hits, f_hits(first + j, tag));
            check(rd_bcid == f_bcid(first + j, tag),
                  roll ? "R4 roll bcid" : (n < D ? "R5 partial bcid" : "R3 first bcid"),
                  rd_bcid, f_bcid(first + j, tag));
        end
        @(negedge clk);
        rd_start  = 1'b0;
        evt_valid = 1'b0;
        check(rd_done == 1'b1 && rd_valid == 1'b0, "R6 done after last", rd_done, 1);
        @(negedge clk);
        check(rd_done == 1'b0, "R6 done one cycle", rd_done, 0);
        check(mem_full == (n >= D), "R8 full kept by readout", mem_full, (n >= D));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0 && rd_done == 1'b0, "R1 outputs idle", rd_valid, 0);
        check(mem_full == 1'b0, "R1 not full", mem_full, 0);
        rst_n = 1'b1;

        // Sweep both modes over event counts from empty to well past the depth.
        for (int roll = 0; roll < 2; roll++) begin
            for (int n = 0; n <= 2 * D + 2; n++) begin
                do_acq(roll[0], n, roll * 20 + n);
                do_read(roll[0], n, roll * 20 + n, 1'b0);
            end
        end

        // R8: noise during readout changes nothing; repeat readout identical.
        do_acq(1'b1, D + 2, 50);
        do_read(1'b1, D + 2, 50, 1'b1);
        do_read(1'b1, D + 2, 50, 1'b0);
        do_acq(1'b0, 3, 51);
        do_read(1'b0, 3, 51, 1'b1);
        do_read(1'b0, 3, 51, 1'b0);

        // R7: clear with a simultaneous event drops the event.
        do_acq(1'b0, 3, 52);
        @(negedge clk);
        acq_start = 1'b1;
        evt_valid = 1'b1;
        @(negedge clk);
        acq_start = 1'b0;
        evt_valid = 1'b0;
        do_read(1'b0, 0, 52, 1'b0);

        // R7: clear in the middle of a readout stops it without done.
        do_acq(1'b1, D + 1, 53);
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        repeat (2) @(negedge clk);
        check(rd_valid == 1'b1 && rd_hits == f_hits(2, 53), "R7 stream before abort", rd_hits, f_hits(2, 53));
        acq_start = 1'b1;
        @(negedge clk);
        acq_start = 1'b0;
        check(rd_valid == 1'b0 && rd_done == 1'b0, "R7 abort stops stream", rd_valid, 0);
        repeat (D + 2) begin
            @(negedge clk);
            check(rd_valid == 1'b0 && rd_done == 1'b0, "R7 no done after abort", rd_done, 0);
        end
        check(mem_full == 1'b0, "R7 empty after abort", mem_full, 0);

        // R1: reset mid-acquisition empties the store.
        do_acq(1'b1, D, 54);
        check(mem_full == 1'b1, "R2 full at depth", mem_full, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(mem_full == 1'b0 && rd_valid == 1'b0, "R1 reset clears full", mem_full, 0);
        rst_n = 1'b1;
        do_read(1'b1, 0, 54, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule